// File: doc/BRIEF.md
# JTAG Test Access Port Controller with Instruction Decoder

This block is the serial test port of a chip. It runs the sixteen-state test-port state machine from the test clock and mode inputs. It holds a 4-bit instruction register. A fixed opcode map in that register picks which data register sits between the serial input and the serial output. The data registers are a 32-bit device-identification register, a 1-bit bypass register and a boundary register of parameterized length.

Towards the core, the boundary register samples a capture bus and keeps a separate preload/update register. An enable tells the pad ring to drive the preloaded values onto the pins. Three other core-side signals are a three-state-all-pins request, a functional-reset request, and a forward flag. The forward flag is raised for opcodes that belong to an external debug port, and the serial output is then taken from that port. The serial output changes on the falling test-clock edge, and its enable is high only while a register is being shifted.

Top module: `tap_ctrl`

## Requirements
- R1: The asynchronous `trst_n` puts the state machine in Test-Logic-Reset with opcode 0000 in the instruction register and every core-side request low. Entering Test-Logic-Reset by clock does the same, except that `bsr_preload_out` is left as it is.
- R2: The Capture-IR state loads 0001 into the instruction shifter, so the first four bits shifted out are 1,0,0,0. A new opcode changes the block's behaviour only at Update-IR and not while it is being shifted.
- R3: Opcode 0000 selects the 32-bit identification register. It is shifted least significant bit first, and its bit 0 is always 1.
- R4: Leaving Shift-DR after only part of a register has been shifted leaves the block intact. A following capture of the identification register returns the full value again.
- R5: Opcode 0010 captures `bsr_capture_in` in Capture-DR and copies the boundary shifter to `bsr_preload_out` in Update-DR. It leaves `bsr_drive_en`, `pins_hiz` and `func_reset_req` low.
- R6: Opcode 0011 captures `bsr_capture_in` the same way, but Update-DR does not change `bsr_preload_out`.
- R7: Opcode 0100 captures and updates the boundary register like 0010. It also raises `bsr_drive_en` and `func_reset_req`.
- R8: Opcode 1001 raises `pins_hiz` and `func_reset_req` and selects the bypass register.
- R9: Opcodes 0001, 0101, 0110, 0111 and 1011 to 1111 select the 1-bit bypass register. It captures 0, so a shifted pattern comes out delayed by one bit behind a leading 0. These opcodes raise no core-side request.
- R10: Opcodes 1000 and 1010 raise `dbg_fwd`. While one of them is loaded, the value on `dbg_tdo` is presented on `tdo` during Shift-DR.
- R11: `tdo` changes only on falling edges of `tck`. `tdo_oe` is high only in the cycles that follow the Shift-IR or Shift-DR state.
- R12: Five rising clock edges with `tms` high reach Test-Logic-Reset from any state, including the middle of a data shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_capture_in | input | BSR_LEN | Pin values sampled into the boundary register |
| bsr_preload_out | output | BSR_LEN | Preload/update register driven towards the pins |
| bsr_drive_en | output | 1 | Pins take `bsr_preload_out` (external test mode) |
| pins_hiz | output | 1 | Request to three-state all outputs |
| func_reset_req | output | 1 | Functional reset request towards the core |
| dbg_fwd | output | 1 | Current opcode belongs to the external debug port |
| dbg_tdo | input | 1 | Serial output of the external debug port |

## Verification
A wrong state-machine state shows up within one scan. The capture pattern of 0001 or the identification word comes out shifted or corrupted, or `tdo_oe` rises in the wrong cycle. A wrong instruction register shows up immediately after the next Update-IR in two ways: as a wrong level on one of the core-side requests, or as the wrong data-register length. The bypass delay of one bit and the 32-bit identification length tell these apart. Boundary-register faults show up in the next Capture-DR through the captured pattern, and in the cycle after Update-DR through `bsr_preload_out`.

// File: rtl/tap_ctrl.sv
module tap_ctrl #(
  parameter logic [31:0] ID_VALUE = 32'h4B1D_70C3,
  parameter int          BSR_LEN  = 8
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] bsr_capture_in,
  output logic [BSR_LEN-1:0] bsr_preload_out,
  output logic               bsr_drive_en,
  output logic               pins_hiz,
  output logic               func_reset_req,
  output logic               dbg_fwd,
  input  logic               dbg_tdo
);
  localparam logic [31:0] ID_WORD  = {ID_VALUE[31:1], 1'b1};
  localparam logic [3:0]  OP_ID    = 4'b0000;
  localparam logic [3:0]  OP_PRE   = 4'b0010;
  localparam logic [3:0]  OP_SMP   = 4'b0011;
  localparam logic [3:0]  OP_EXT   = 4'b0100;
  localparam logic [3:0]  OP_DBG0  = 4'b1000;
  localparam logic [3:0]  OP_HIZ   = 4'b1001;
  localparam logic [3:0]  OP_DBG1  = 4'b1010;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PA_DR, S_EX2_DR, S_UPD_DR,
    S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PA_IR, S_EX2_IR, S_UPD_IR
  } tap_state_e;

  tap_state_e state, nstate;
  logic [3:0]         ir, ir_sr;
  logic [31:0]        id_sr;
  logic               byp;
  logic [BSR_LEN-1:0] bsr_sr;
  logic               sel_id, sel_bsr, serial_out;

  always_comb begin
    unique case (state)
      S_TLR:    nstate = tms ? S_TLR    : S_RTI;
      S_RTI:    nstate = tms ? S_SEL_DR : S_RTI;
      S_SEL_DR: nstate = tms ? S_SEL_IR : S_CAP_DR;
      S_CAP_DR: nstate = tms ? S_EX1_DR : S_SH_DR;
      S_SH_DR:  nstate = tms ? S_EX1_DR : S_SH_DR;
      S_EX1_DR: nstate = tms ? S_UPD_DR : S_PA_DR;
      S_PA_DR:  nstate = tms ? S_EX2_DR : S_PA_DR;
      S_EX2_DR: nstate = tms ? S_UPD_DR : S_SH_DR;
      S_UPD_DR: nstate = tms ? S_SEL_DR : S_RTI;
      S_SEL_IR: nstate = tms ? S_TLR    : S_CAP_IR;
      S_CAP_IR: nstate = tms ? S_EX1_IR : S_SH_IR;
      S_SH_IR:  nstate = tms ? S_EX1_IR : S_SH_IR;
      S_EX1_IR: nstate = tms ? S_UPD_IR : S_PA_IR;
      S_PA_IR:  nstate = tms ? S_EX2_IR : S_PA_IR;
      S_EX2_IR: nstate = tms ? S_UPD_IR : S_SH_IR;
      S_UPD_IR: nstate = tms ? S_SEL_DR : S_RTI;
      default:  nstate = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_TLR;
    else         state <= nstate;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)                ir <= OP_ID;
    else if (nstate == S_TLR)   ir <= OP_ID;
    else if (state == S_UPD_IR) ir <= ir_sr;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)                ir_sr <= 4'b0001;
    else if (state == S_CAP_IR) ir_sr <= 4'b0001;
    else if (state == S_SH_IR)  ir_sr <= {tdi, ir_sr[3:1]};

  assign sel_id  = (ir == OP_ID);
  assign sel_bsr = (ir == OP_PRE) || (ir == OP_SMP) || (ir == OP_EXT);

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      id_sr  <= '0;
      byp    <= 1'b0;
      bsr_sr <= '0;
    end else if (state == S_CAP_DR) begin
      if (sel_id)  id_sr  <= ID_WORD;
      if (sel_bsr) bsr_sr <= bsr_capture_in;
      byp <= 1'b0;
    end else if (state == S_SH_DR) begin
      if (sel_id)                id_sr  <= {tdi, id_sr[31:1]};
      else if (sel_bsr)          bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
      else                       byp    <= tdi;
    end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) bsr_preload_out <= '0;
    else if (state == S_UPD_DR && (ir == OP_PRE || ir == OP_EXT)) bsr_preload_out <= bsr_sr;

  assign bsr_drive_en   = (ir == OP_EXT);
  assign pins_hiz       = (ir == OP_HIZ);
  assign func_reset_req = bsr_drive_en || pins_hiz;
  assign dbg_fwd        = (ir == OP_DBG0) || (ir == OP_DBG1);

  always_comb begin
    if (state == S_SH_IR)  serial_out = ir_sr[0];
    else if (dbg_fwd)      serial_out = dbg_tdo;
    else if (sel_id)       serial_out = id_sr[0];
    else if (sel_bsr)      serial_out = bsr_sr[0];
    else                   serial_out = byp;
  end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= serial_out;
      tdo_oe <= (state == S_SH_IR) || (state == S_SH_DR);
    end

  assert_tlr_loads_id_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_TLR) |=> (ir == OP_ID));
  assert_ir_only_at_update_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (state != S_UPD_IR && nstate != S_TLR) |=> $stable(ir));
  assert_capture_ir_pattern_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_CAP_IR) |=> (ir_sr == 4'b0001));
  assert_preload_only_at_update_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (state != S_UPD_DR) |=> $stable(bsr_preload_out));
  assert_sample_keeps_preload_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (state == S_UPD_DR && ir == OP_SMP) |=> $stable(bsr_preload_out));
  assert_func_reset_from_update_R7: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(func_reset_req) |-> ($past(state) == S_UPD_IR));
  assert_oe_in_shift_only_R11: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == S_SH_IR || state == S_SH_DR));
endmodule

// File: tb/test_tap_ctrl.sv
module test_tap_ctrl;
  localparam logic [31:0] ID_VALUE = 32'h4B1D_70C3;
  localparam int          BSR_LEN  = 8;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0, dbg_tdo = 1'b0;
  logic tdo, tdo_oe, bsr_drive_en, pins_hiz, func_reset_req, dbg_fwd;
  logic [BSR_LEN-1:0] bsr_capture_in = '0, bsr_preload_out;
  int checks = 0, failures = 0;
  bit oe_bad = 0, edge_bad = 0, done = 0;

  tap_ctrl #(.ID_VALUE(ID_VALUE), .BSR_LEN(BSR_LEN)) i_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_capture_in(bsr_capture_in), .bsr_preload_out(bsr_preload_out),
    .bsr_drive_en(bsr_drive_en), .pins_hiz(pins_hiz), .func_reset_req(func_reset_req),
    .dbg_fwd(dbg_fwd), .dbg_tdo(dbg_tdo));

  always #5 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o, output logic oe);
    @(negedge tck); #1;
    o = tdo; oe = tdo_oe; tms = m; tdi = d;
    @(posedge tck); #1;
    if (tdo !== o) edge_bad = 1;
  endtask

  task automatic go(input logic m);
    logic o, oe;
    step(m, 1'b0, o, oe);
  endtask

  task automatic scan_ir(input logic [3:0] op, output logic [3:0] cap);
    logic o, oe;
    go(1); go(1); go(0); go(0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], o, oe);
      cap[i] = o;
      if (oe !== 1'b1) oe_bad = 1;
    end
    go(1); go(0);
  endtask

  task automatic load_ir(input logic [3:0] op);
    logic [3:0] cap;
    scan_ir(op, cap);
    chk(cap == 4'b0001, "R2 capture-IR pattern", cap, 4'b0001);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] d, output logic [63:0] r);
    logic o, oe;
    r = '0;
    go(1); go(0); go(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, d[i], o, oe);
      r[i] = o;
      if (oe !== 1'b1) oe_bad = 1;
    end
    go(1); go(0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    logic [31:0] id_exp;
    logic [7:0]  a, b;
    id_exp = {ID_VALUE[31:1], 1'b1};
    #23 trst_n = 1'b1;
    #10;
    chk({bsr_drive_en, pins_hiz, func_reset_req, dbg_fwd, tdo_oe} == 5'b0, "R1 reset outputs",
        {bsr_drive_en, pins_hiz, func_reset_req, dbg_fwd, tdo_oe}, 0);
    go(0);
    // R3 identification word after reset (R1: opcode 0000)
    scan_dr(32, 64'h0, r);
    chk(r[31:0] == id_exp, "R3 idcode", r[31:0], id_exp);
    chk(r[0] == 1'b1, "R3 id lsb", r[0], 1);
    // R4 partial shift then full read
    scan_dr(8, 64'hFF, r);
    chk(r[7:0] == id_exp[7:0], "R4 partial id", r[7:0], id_exp[7:0]);
    scan_dr(32, 64'hFFFF_FFFF, r);
    chk(r[31:0] == id_exp, "R4 full id after partial", r[31:0], id_exp);
    // R5 sample/preload
    load_ir(4'b0010);
    bsr_capture_in = 8'hA5;
    scan_dr(8, 64'h3C, r);
    chk(r[7:0] == 8'hA5, "R5 capture", r[7:0], 8'hA5);
    chk(bsr_preload_out == 8'h3C, "R5 preload", bsr_preload_out, 8'h3C);
    chk({bsr_drive_en, pins_hiz, func_reset_req} == 3'b0, "R5 no pin effect",
        {bsr_drive_en, pins_hiz, func_reset_req}, 0);
    // R6 sample only
    load_ir(4'b0011);
    bsr_capture_in = 8'h5A;
    scan_dr(8, 64'hFF, r);
    chk(r[7:0] == 8'h5A, "R6 capture", r[7:0], 8'h5A);
    chk(bsr_preload_out == 8'h3C, "R6 preload unchanged", bsr_preload_out, 8'h3C);
    chk(func_reset_req == 1'b0, "R6 no reset", func_reset_req, 0);
    // R7 external test, sweep of patterns
    load_ir(4'b0100);
    chk(bsr_drive_en && func_reset_req && !pins_hiz, "R7 flags",
        {bsr_drive_en, pins_hiz, func_reset_req}, 3'b101);
    for (int k = 0; k < 8; k++) begin
      a = 8'(k * 37 + 1);
      b = 8'(k * 91) ^ 8'h55;
      bsr_capture_in = a;
      scan_dr(8, {56'h0, b}, r);
      chk(r[7:0] == a, "R7 capture", r[7:0], a);
      chk(bsr_preload_out == b, "R7 update", bsr_preload_out, b);
    end
    // R12 / R1: five TMS-high clocks from Run-Test-Idle
    for (int i = 0; i < 5; i++) go(1);
    chk({bsr_drive_en, func_reset_req} == 2'b0, "R12 reset clears extest",
        {bsr_drive_en, func_reset_req}, 0);
    go(0);
    scan_dr(32, 64'h0, r);
    chk(r[31:0] == id_exp, "R1 idcode after tms reset", r[31:0], id_exp);
    // R2 / R8: opcode takes effect at Update-IR only
    begin
      logic o, oe;
      logic [3:0] op;
      op = 4'b1001;
      go(1); go(1); go(0); go(0);
      for (int i = 0; i < 4; i++) step(i == 3, op[i], o, oe);
      chk(pins_hiz == 1'b0, "R2 no effect before update", pins_hiz, 0);
      go(1); go(0);
    end
    chk(pins_hiz && func_reset_req && !bsr_drive_en, "R8 highz flags",
        {bsr_drive_en, pins_hiz, func_reset_req}, 3'b011);
    scan_dr(8, 64'hB6, r);
    chk(r[7:0] == 8'h6C, "R8 bypass", r[7:0], 8'h6C);
    // R12 from the middle of Shift-DR
    go(1); go(0); go(0); go(0);
    for (int i = 0; i < 5; i++) go(1);
    chk({pins_hiz, func_reset_req} == 2'b0, "R12 reset from shift-dr",
        {pins_hiz, func_reset_req}, 0);
    go(0);
    // R9 reserved opcodes sweep
    for (int op = 0; op < 16; op++) begin
      if (op == 1 || (op >= 5 && op <= 7) || op >= 11) begin
        a = 8'(op * 17 + 3);
        load_ir(4'(op));
        scan_dr(8, {56'h0, a}, r);
        chk(r[7:0] == {a[6:0], 1'b0}, "R9 bypass", r[7:0], {a[6:0], 1'b0});
        chk({bsr_drive_en, pins_hiz, func_reset_req, dbg_fwd} == 4'b0, "R9 no flags",
            {bsr_drive_en, pins_hiz, func_reset_req, dbg_fwd}, 0);
      end
    end
    // R10 debug forwarding
    load_ir(4'b1000);
    chk(dbg_fwd == 1'b1, "R10 fwd 1000", dbg_fwd, 1);
    dbg_tdo = 1'b1;
    scan_dr(4, 64'h0, r);
    chk(r[3:0] == 4'hF, "R10 tdo from debug port", r[3:0], 4'hF);
    dbg_tdo = 1'b0;
    load_ir(4'b1010);
    chk(dbg_fwd == 1'b1, "R10 fwd 1010", dbg_fwd, 1);
    scan_dr(4, 64'hF, r);
    chk(r[3:0] == 4'h0, "R10 tdo follows debug low", r[3:0], 0);
    load_ir(4'b0000);
    chk(dbg_fwd == 1'b0, "R10 fwd cleared", dbg_fwd, 0);
    // R11 output enable and falling-edge timing
    #3;
    chk(tdo_oe == 1'b0, "R11 oe low in idle", tdo_oe, 0);
    chk(!oe_bad, "R11 oe high during shifts", oe_bad, 0);
    chk(!edge_bad, "R11 tdo stable at rising edge", edge_bad, 0);
    // R1 asynchronous reset clears effects but uses trst
    load_ir(4'b0100);
    trst_n = 1'b0; #3;
    chk({bsr_drive_en, func_reset_req} == 2'b0, "R1 trst clears", {bsr_drive_en, func_reset_req}, 0);
    #10 trst_n = 1'b1;
    go(0);
    scan_dr(32, 64'h0, r);
    chk(r[31:0] == id_exp, "R1 idcode after trst", r[31:0], id_exp);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule